// File: doc/BRIEF.md
# PWM Dead-Band Delay Generator

This block takes two PWM signals, A and B, and returns two gate-drive signals with dead time between them. Two delay stages are fed from input A. The first holds back the leading (low-to-high) transition by a programmed count. The second holds back the trailing (high-to-low) transition by an independent count. A 2-bit routing field decides, separately for each output, whether it takes its delay stage or its raw input. A 2-bit polarity field can invert either delayed path when both stages are in use. The block is used to build complementary or same-phase drive pairs for half-bridge power stages.

Delay counts are measured in time-base ticks. The block runs from a fast clock at twice the time-base rate, and a strobe marks each time-base period. When half-period resolution is enabled, the counters advance on every fast-clock cycle instead of only on the strobe, so each count unit becomes half a time-base period.

Top module: `dead_band_gen`

## Requirements
- R1: A synchronous active-high reset clears both delay counters. With input A low, both delay-stage outputs are low after reset, so with route 11 and polarity 00 both outputs read 0.
- R2: A delay count of 0 gives no delay: the stage output equals input A in the same cycle.
- R3: With half-period resolution on, the leading-edge stage output rises exactly `rise_cnt` fast-clock cycles after input A rises and stays high, and it falls in the same cycle that A falls.
- R4: With half-period resolution off, both counters advance only in cycles where `tb_tick` is 1, so a delay of N spans N strobes.
- R5: A falling edge on A clears the leading-edge stage output at once and restarts its count. A high pulse shorter than the leading delay produces no output pulse at all. In the same way, a low gap shorter than the trailing delay leaves the trailing-stage output high throughout.
- R6: The trailing-edge stage output rises in the same cycle as A. After A falls, it stays high for `fall_cnt` counter advances.
- R7: Route `route_sel` = 00 passes input A to `pwm_a_out` and input B to `pwm_b_out`, with no delay.
- R8: Route 01 passes A straight to `pwm_a_out` and drives `pwm_b_out` from the trailing-edge stage.
- R9: Route 10 drives `pwm_a_out` from the leading-edge stage and passes input B straight to `pwm_b_out`.
- R10: Under route 11, polarity bit 0 inverts the leading-delay path on `pwm_a_out` and bit 1 inverts the trailing-delay path on `pwm_b_out`. The codes are 00 for active high, 01 for active low complementary, 10 for active high complementary and 11 for active low.
- R11: Under routes 00, 01 and 10, the polarity field has no effect on either output.
- R12: The leading and trailing counts are independent, so different values give different delays on the two paths at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the time-base rate |
| rst | input | 1 | Synchronous active-high reset |
| tb_tick | input | 1 | One-cycle strobe per time-base period |
| half_cycle_en | input | 1 | 1: counters advance every fast cycle |
| pwm_a_in | input | 1 | PWM input A, source of both delay stages |
| pwm_b_in | input | 1 | PWM input B, used only when passed straight through |
| rise_cnt | input | 10 | Leading-edge delay count |
| fall_cnt | input | 10 | Trailing-edge delay count |
| route_sel | input | 2 | Bit 1: A output takes the leading stage; bit 0: B output takes the trailing stage |
| pol_sel | input | 2 | Bit 0 inverts the leading path, bit 1 inverts the trailing path (route 11 only) |
| pwm_a_out | output | 1 | Gate-drive output A |
| pwm_b_out | output | 1 | Gate-drive output B |

## Verification
The bench goes after pulses and gaps shorter than the programmed delay, where a design that forgot to restart its count would let a late, truncated pulse through. It also covers zero counts: an off-by-one counter would add a stray cycle of delay there. The bench checks strobe-only advancing, which a design that counts every cycle would finish twice too early. It also sets polarity codes under the bypass routes, where a design that inverts unconditionally would flip a raw input.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

    localparam int DLY_W = 10;

    typedef enum logic [1:0] {
        ROUTE_PASS   = 2'b00,
        ROUTE_B_FALL = 2'b01,
        ROUTE_A_RISE = 2'b10,
        ROUTE_FULL   = 2'b11
    } route_e;

    typedef struct packed {
        logic inv_fall;
        logic inv_rise;
    } pol_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } stage_pair_t;

    function automatic logic flip(input logic v, input logic en);
        return v ^ en;
    endfunction

endpackage

// File: rtl/dbg_edge_stage.sv
module dbg_edge_stage #(
    parameter int   W          = dbg_pkg::DLY_W,
    parameter logic DELAY_FALL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         sig_in,
    input  logic [W-1:0] dly,
    output logic         sig_out
);
    logic         x;
    logic         y;
    logic         done;
    logic [W-1:0] cnt;
    logic [W:0]   next_cnt;

    // Work on the level whose arrival is delayed; mirror for the trailing stage.
    assign x        = DELAY_FALL ? ~sig_in : sig_in;
    assign next_cnt = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            done <= DELAY_FALL;
        end else if (!x) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done && adv) begin
            if (next_cnt >= {1'b0, dly})
                done <= 1'b1;
            else
                cnt <= next_cnt[W-1:0];
        end
    end

    assign y       = (dly == '0) ? x : (x & done);
    assign sig_out = DELAY_FALL ? ~y : y;

    // R3: the delayed level appears only after the source has been at it
    assert_rise_after_high_R3: assert property (@(posedge clk) disable iff (rst)
        (dly != '0 && $stable(dly) && !$past(rst) && $rose(y)) |-> $past(x));

    // R4: without an advance the count holds
    assert_hold_count_R4: assert property (@(posedge clk) disable iff (rst)
        $past(!adv && x && !rst) |-> $stable(cnt));

    // R5: dropping the source restarts the stage
    assert_restart_on_drop_R5: assert property (@(posedge clk) disable iff (rst)
        $past(!x && !rst) |-> (cnt == '0 && !done));

endmodule

// File: rtl/dbg_out_route.sv
module dbg_out_route
    import dbg_pkg::*;
(
    input  route_e      mode,
    input  pol_t        pol,
    input  logic        a_in,
    input  logic        b_in,
    input  stage_pair_t st,
    output logic        a_out,
    output logic        b_out
);
    logic full;

    assign full = (mode == ROUTE_FULL);

    always_comb begin
        a_out = mode[1] ? flip(st.rise, full & pol.inv_rise) : a_in;
        b_out = mode[0] ? flip(st.fall, full & pol.inv_fall) : b_in;
    end

endmodule

// File: rtl/dead_band_gen.sv
module dead_band_gen
    import dbg_pkg::*;
#(
    parameter int W = DLY_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tb_tick,
    input  logic         half_cycle_en,
    input  logic         pwm_a_in,
    input  logic         pwm_b_in,
    input  logic [W-1:0] rise_cnt,
    input  logic [W-1:0] fall_cnt,
    input  logic [1:0]   route_sel,
    input  logic [1:0]   pol_sel,
    output logic         pwm_a_out,
    output logic         pwm_b_out
);
    logic        adv;
    stage_pair_t st;
    route_e      mode;
    pol_t        pol;

    assign adv  = half_cycle_en | tb_tick;
    assign mode = route_e'(route_sel);
    assign pol  = pol_t'(pol_sel);

    dbg_edge_stage #(.W(W), .DELAY_FALL(1'b0)) u_rise (
        .clk(clk), .rst(rst), .adv(adv), .sig_in(pwm_a_in),
        .dly(rise_cnt), .sig_out(st.rise)
    );

    dbg_edge_stage #(.W(W), .DELAY_FALL(1'b1)) u_fall (
        .clk(clk), .rst(rst), .adv(adv), .sig_in(pwm_a_in),
        .dly(fall_cnt), .sig_out(st.fall)
    );

    dbg_out_route u_route (
        .mode(mode), .pol(pol), .a_in(pwm_a_in), .b_in(pwm_b_in),
        .st(st), .a_out(pwm_a_out), .b_out(pwm_b_out)
    );

    // R7: pass route leaves both inputs untouched
    assert_pass_route_R7: assert property (@(posedge clk) disable iff (rst)
        (route_sel == 2'b00) |-> (pwm_a_out == pwm_a_in && pwm_b_out == pwm_b_in));

    // R8: A is passed straight through when only B is delayed
    assert_a_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (route_sel == 2'b01) |-> (pwm_a_out == pwm_a_in));

    // R9: B is passed straight through when only A is delayed
    assert_b_bypass_R9: assert property (@(posedge clk) disable iff (rst)
        (route_sel == 2'b10) |-> (pwm_b_out == pwm_b_in));

endmodule

// File: tb/dead_band_gen_bench.sv
module dead_band_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SAT = 4096;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tb_tick = 1'b0;
    logic       half_en = 1'b1;
    logic       a_in = 1'b0;
    logic       b_in = 1'b0;
    logic [9:0] rd = 10'd5;
    logic [9:0] fd = 10'd7;
    logic [1:0] route = 2'b11;
    logic [1:0] pol = 2'b00;
    logic       a_out;
    logic       b_out;

    int    n_checks = 0;
    int    n_fail = 0;
    int    r_run = 0;
    int    f_run = SAT;
    int    cyc = 0;
    string cur_req = "R1";

    dead_band_gen u_dead_band_gen (
        .clk(clk), .rst(rst), .tb_tick(tb_tick), .half_cycle_en(half_en),
        .pwm_a_in(a_in), .pwm_b_in(b_in), .rise_cnt(rd), .fall_cnt(fd),
        .route_sel(route), .pol_sel(pol), .pwm_a_out(a_out), .pwm_b_out(b_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // strobe every other fast cycle
    always @(negedge clk) begin
        if (rst) tb_tick <= 1'b0;
        else     tb_tick <= ~tb_tick;
    end

    // behavioural reference: run lengths measured in advances
    always @(posedge clk) begin
        if (rst) begin
            r_run = 0;
            f_run = SAT;
        end else begin
            if (!a_in) r_run = 0;
            else if ((half_en || tb_tick) && r_run < SAT) r_run++;
            if (a_in) f_run = 0;
            else if ((half_en || tb_tick) && f_run < SAT) f_run++;
        end
    end

    task automatic compare();
        logic er, ef, ea, eb;
        er = a_in && (rd == 0 || r_run >= int'(rd));
        ef = a_in || (fd != 0 && f_run < int'(fd));
        ea = route[1] ? (er ^ (route == 2'b11 && pol[0])) : a_in;
        eb = route[0] ? (ef ^ (route == 2'b11 && pol[1])) : b_in;
        n_checks++;
        if (a_out !== ea || b_out !== eb) begin
            n_fail++;
            $display("FAIL %s cycle %0d: out a=%b b=%b expected a=%b b=%b",
                     cur_req, cyc, a_out, b_out, ea, eb);
        end
    endtask

    task automatic step(input logic a);
        @(negedge clk);
        a_in = a;
        b_in = cyc[2];
        cyc++;
        #1 compare();
    endtask

    task automatic pulse(input int hi, input int lo);
        for (int i = 0; i < hi; i++) step(1'b1);
        for (int i = 0; i < lo; i++) step(1'b0);
    endtask

    // idle long enough for both stages to settle, then change settings
    task automatic setup(input string req, input logic h, input int r, input int f,
                         input logic [1:0] rt, input logic [1:0] p);
        for (int i = 0; i < 30; i++) step(1'b0);
        @(negedge clk);
        cur_req = req;
        half_en = h;
        rd = r[9:0];
        fd = f[9:0];
        route = rt;
        pol = p;
        #1 compare();
        for (int i = 0; i < 3; i++) step(1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: after reset with A low, both outputs low under route 11, polarity 00
        cur_req = "R1";
        n_checks++;
        if (a_out !== 1'b0 || b_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: out a=%b b=%b expected a=0 b=0", a_out, b_out);
        end
        pulse(12, 12);

        setup("R7", 1'b1, 5, 7, 2'b00, 2'b11);
        pulse(3, 5); pulse(9, 2); pulse(1, 1);

        setup("R2", 1'b1, 0, 0, 2'b11, 2'b00);
        pulse(1, 1); pulse(4, 3);

        setup("R3", 1'b1, 3, 4, 2'b11, 2'b00);
        pulse(8, 8); pulse(3, 8); pulse(4, 10);

        setup("R4", 1'b0, 3, 2, 2'b11, 2'b00);
        pulse(12, 12); pulse(5, 3); pulse(7, 9);

        setup("R5", 1'b1, 6, 6, 2'b11, 2'b00);
        pulse(3, 2); pulse(5, 1); pulse(2, 5); pulse(9, 9);

        setup("R6", 1'b1, 0, 5, 2'b11, 2'b00);
        pulse(6, 7); pulse(2, 4);

        setup("R8", 1'b1, 4, 3, 2'b01, 2'b00);
        pulse(6, 6); pulse(2, 2);

        setup("R9", 1'b1, 4, 3, 2'b10, 2'b00);
        pulse(6, 6); pulse(3, 3);

        for (int p = 1; p < 4; p++) begin
            setup("R10", 1'b1, 2, 3, 2'b11, p[1:0]);
            pulse(6, 6); pulse(1, 2);
        end

        setup("R11", 1'b1, 3, 2, 2'b01, 2'b11);
        pulse(6, 6);
        setup("R11", 1'b1, 3, 2, 2'b10, 2'b11);
        pulse(6, 6);
        setup("R11", 1'b1, 3, 2, 2'b00, 2'b10);
        pulse(5, 5);

        setup("R12", 1'b1, 2, 9, 2'b11, 2'b10);
        pulse(10, 12); pulse(4, 3);
        setup("R12", 1'b0, 7, 1, 2'b11, 2'b00);
        pulse(18, 6);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule